// File: doc/BRIEF.md
# Parallel-in serial-out shift register

This block is a chain of storage stages that can be filled in two ways: all at once from a parallel word, or one bit at a time from a serial input. The last stage drives two outputs, one carrying its value and one carrying the complement. A load control picks between the two ways of filling. While load is active, the stages copy the parallel word and keep copying it. While load is inactive, the chain moves one place toward the last stage on each shift event, and the serial bit enters the first stage.

A shift event is a rising edge of the OR of two interchangeable clock pins, so either pin can act as the shift clock while the other acts as an active-high inhibit. Raising the inhibit while the clock pin is low also produces a rising OR, and that costs one extra shift. The pins are not used as real clocks. The load control, both clock pins and the serial input are brought into the system-clock domain through flop synchronisers, and the OR is edge-detected there. The parallel word is sampled directly on each system clock while the synchronised load is active.

The reset input asserts asynchronously and releases synchronously. Because the edge-history flop tracks the pins during reset, a clock pin that is already high at release does not cause a shift.

Top module: `piso_shift_reg`

## Requirements
- R1: While reset is active, and on the first cycle after it releases, every stage is zero, so `q` is 0 and `q_n` is 1.
- R2: While `load_n` is low, stage k copies `par_in[k]` on every system clock. `par_in[0]` feeds the first stage and `par_in[WIDTH-1]` feeds the last stage, so after a load `q` equals `par_in[WIDTH-1]`.
- R3: While `load_n` is low, activity on `clk_a` and `clk_b` has no effect and the stages keep following `par_in`.
- R4: While `load_n` is high, each low-to-high change of `clk_a | clk_b` moves stage k into stage k+1 and puts `ser_in` into stage 0. A pin change reaches `q` on the third rising system clock edge after it.
- R5: While either clock pin stays high, toggling the other pin causes no shift.
- R6: If `clk_b` rises while `clk_a` is low (and the reverse), one shift occurs. This is the double-clock case.
- R7: With no rising edge of `clk_a | clk_b` and `load_n` high, the stages hold their values for any number of cycles.
- R8: `q_n` is always the complement of `q`.
- R9: Releasing reset while a clock pin is already high causes no shift.
- R10: Driving `load_n` low in the middle of a shift sequence overrides shifting, and the parallel word reaches the outputs within three system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously inside the block |
| load_n | input | 1 | Low: parallel load; high: shift mode (asynchronous pin) |
| clk_a | input | 1 | Shift clock pin A; when held high it inhibits pin B |
| clk_b | input | 1 | Shift clock pin B; when held high it inhibits pin A |
| ser_in | input | 1 | Serial bit taken into the first stage on a shift |
| par_in | input | WIDTH | Parallel word; bit 0 goes to the first stage |
| q | output | 1 | Last stage, true |
| q_n | output | 1 | Last stage, inverted |

## Verification
The assertions rely on the synchronised views of the pins: each pin level is assumed to last at least two system cycles, so every edge survives the synchroniser as one clean step. `ser_in` is assumed steady while a clock pin rises, and `par_in` is assumed steady through the last synchroniser window before `load_n` rises. The stimulus drives every pin on the falling system edge, holds each new level for four system cycles, and changes `ser_in` and `par_in` only alongside or before the pin change that uses them. This keeps every edge and every sampled value unambiguous.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } piso_mode_e;

  localparam int unsigned PISO_DEF_WIDTH = 8;
  localparam int unsigned PISO_DEF_SYNC  = 2;

endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  // Synchroniser flops carry no reset so they flush pin levels during reset.
  always_ff @(posedge clk) begin
    pipe_q[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_a_s,
  input  logic clk_b_s,
  output logic rise
);
  logic or_now;
  logic hist_q;

  assign or_now = clk_a_s | clk_b_s;

  // History follows the OR even in reset, so release never sees a false edge.
  always_ff @(posedge clk) begin
    hist_q <= or_now;
  end

  assign rise = or_now & ~hist_q;

  // R5
  held_high_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clk_a_s) && clk_a_s) || ($past(clk_b_s) && clk_b_s)) |-> !rise);

  // R6
  inhibit_edge_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clk_a_s) && !$past(clk_b_s) && (clk_a_s || clk_b_s)) |-> rise);
endmodule

// File: rtl/piso_stages.sv
module piso_stages
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n_s,
  input  logic             rise,
  input  logic             ser_s,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stages
);
  piso_mode_e       mode;
  logic [WIDTH-1:0] stages_d;
  logic [WIDTH-1:0] stages_q;
  logic             stages_en;

  always_comb begin
    if (!load_n_s) begin
      mode = MODE_LOAD;
    end else if (rise) begin
      mode = MODE_SHIFT;
    end else begin
      mode = MODE_HOLD;
    end
  end

  always_comb begin
    stages_d = stages_q;
    case (mode)
      MODE_LOAD:  stages_d = par_in;
      MODE_SHIFT: stages_d = {stages_q[WIDTH-2:0], ser_s};
      default:    stages_d = stages_q;
    endcase
  end

  assign stages_en = (mode != MODE_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages_q <= '0;
    end else if (stages_en) begin
      stages_q <= stages_d;
    end
  end

  assign stages = stages_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stages_q == '0));

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |=> (stages_q == $past(par_in)));

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n_s && rise) |=> (stages_q == $past(par_in)));

  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && rise) |=>
      (stages_q == {$past(stages_q[WIDTH-2:0]), $past(ser_s)}));

  // R7
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && !rise) |=> $stable(stages_q));
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH       = PISO_DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = PISO_DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q,
  output logic             q_n
);
  localparam int unsigned PIN_W = 4;
  localparam int unsigned IDX_LOAD = 3;
  localparam int unsigned IDX_CA   = 2;
  localparam int unsigned IDX_CB   = 1;
  localparam int unsigned IDX_SER  = 0;

  logic             rst_int_n;
  logic [PIN_W-1:0] pins_s;
  logic             rise;
  logic [WIDTH-1:0] stages;

  piso_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  piso_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .d   ({load_n, clk_a, clk_b, ser_in}),
    .q   (pins_s)
  );

  piso_edge i_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clk_a_s (pins_s[IDX_CA]),
    .clk_b_s (pins_s[IDX_CB]),
    .rise    (rise)
  );

  piso_stages #(.WIDTH(WIDTH)) i_stages (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_n_s (pins_s[IDX_LOAD]),
    .rise     (rise),
    .ser_s    (pins_s[IDX_SER]),
    .par_in   (par_in),
    .stages   (stages)
  );

  assign q   = stages[WIDTH-1];
  assign q_n = ~stages[WIDTH-1];
endmodule

// File: tb/test_piso_shift_reg.sv
module test_piso_shift_reg;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int NVEC  = 15;

  logic clk, rst_n, load_n, clk_a, clk_b, ser_in;
  logic [W-1:0] par_in;
  logic q, q_n;

  int n_run, n_fail;
  bit done;

  // vector: {load_n, clk_a, clk_b, ser_in, par_in[7:0], expected q}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b1},  // 0 R2 load, H bit first
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b1},  // 1 R7 release, hold
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hB2, 1'b0},  // 2 R4 shift, ser 0
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b0},  // 3 falling edge, no shift
    {1'b1, 1'b1, 1'b0, 1'b1, 8'hB2, 1'b1},  // 4 R4 shift, ser 1
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hB2, 1'b1},  // 5
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hB2, 1'b1},  // 6 R6 inhibit rise shifts
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hB2, 1'b1},  // 7 R5 blocked
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hB2, 1'b1},  // 8 R5
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hB2, 1'b1},  // 9 OR falls
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hB2, 1'b0},  // 10 R4 shift, ser 0
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b0},  // 11
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h7F, 1'b0},  // 12 R3 clock ignored in load
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1},  // 13 R2 follows
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1}   // 14 R7 hold after release
  };

  piso_shift_reg i_piso_shift_reg (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .clk_a(clk_a),
    .clk_b(clk_b), .ser_in(ser_in), .par_in(par_in), .q(q), .q_n(q_n)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, q, exp);
    chk("R8", q_n, ~exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] m;
    logic [W-1:0] sp;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; load_n = 1'b1; clk_a = 1'b0; clk_b = 1'b0;
    ser_in = 1'b0; par_in = '0;
    settle(6);
    chk_out("R1", 1'b0);
    @(negedge clk) rst_n = 1'b1;
    settle(5);
    chk_out("R1", 1'b0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {load_n, clk_a, clk_b, ser_in, par_in} = VEC[i][12:1];
      settle(4);
      chk_out($sformatf("R2-R7 vector %0d", i), VEC[i][0]);
    end

    // full shift-out against a model (R4)
    @(negedge clk); load_n = 1'b0; par_in = 8'hA5;
    settle(4);
    m = 8'hA5;
    chk_out("R2", m[W-1]);
    @(negedge clk); load_n = 1'b1;
    settle(4);
    sp = 8'b1100_1010;
    for (int i = 0; i < W; i++) begin
      @(negedge clk); ser_in = sp[i]; clk_a = 1'b1;
      settle(4);
      m = {m[W-2:0], sp[i]};
      chk_out("R4", m[W-1]);
      @(negedge clk); clk_a = 1'b0;
      settle(4);
    end

    // inhibit held high blocks clk_a (R5)
    @(negedge clk); clk_b = 1'b1;
    settle(4);
    m = {m[W-2:0], ser_in};  // R6 raising inhibit with clk_a low shifts once
    chk_out("R6", m[W-1]);
    for (int i = 0; i < W; i++) begin
      @(negedge clk); clk_a = 1'b1; ser_in = ~ser_in;
      settle(4);
      @(negedge clk); clk_a = 1'b0;
      settle(4);
      chk_out("R5", m[W-1]);
    end
    @(negedge clk); clk_b = 1'b0;
    settle(4);
    chk_out("R5", m[W-1]);

    // static hold (R7)
    settle(300);
    chk_out("R7", m[W-1]);

    // load in the middle of shifting (R10)
    @(negedge clk); load_n = 1'b0; par_in = 8'hF0;
    settle(4);
    @(negedge clk); load_n = 1'b1;
    settle(4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ser_in = 1'b0; clk_a = 1'b1;
      settle(4);
      @(negedge clk); clk_a = 1'b0;
      settle(4);
    end
    chk_out("R10", 1'b1);
    @(negedge clk); load_n = 1'b0; par_in = 8'h00; clk_a = 1'b1;
    settle(3);
    chk_out("R10", 1'b0);
    @(negedge clk); load_n = 1'b1; clk_a = 1'b0;
    settle(4);

    // reset release with clock pin high (R9)
    @(negedge clk); rst_n = 1'b0; ser_in = 1'b1; clk_a = 1'b1;
    settle(6);
    @(negedge clk); rst_n = 1'b1;
    settle(6);
    chk_out("R1", 1'b0);
    for (int i = 0; i < W - 1; i++) begin
      @(negedge clk); clk_a = 1'b0; ser_in = 1'b0;
      settle(4);
      @(negedge clk); clk_a = 1'b1;
      settle(4);
    end
    chk_out("R9", 1'b0);

    finish_run();
  end
endmodule